// File: doc/BRIEF.md
# Two-Pattern Scan Test Sequencer

This block runs a mux-D scan chain through a series of two-pattern delay tests. It drives the chain's scan enable, one clock-enable pulse per chain clock and the serial scan-in bit, and it reads the serial scan-out bit. Every test has three steps in a fixed order: an initialization load of the first vector, a launch clock that creates the second vector, and a capture clock that stores the circuit's response. A mode input chooses how the launch happens. In shift-launch mode, scan enable stays high for one extra shift. In capture-launch mode, scan enable drops and the circuit's own logic produces the second vector.

Test bits arrive on a valid/ready input stream. Back-pressure rules: the block raises ready only while it is loading the chain. A bit moves, and a chain pulse fires, only in a cycle where valid and ready are both high. While valid is low the chain holds. Responses leave on an output stream that has a valid strobe and no ready. The consumer must take a bit in every cycle where valid is high. Each test's response is shifted out while the next test's first vector is shifted in. After the last capture, a flush of chain-length shifts empties the chain, and a one-cycle done pulse follows.

Top module: `scan_seq_top`

## Requirements
- R1: A synchronous reset, whether held or applied in the middle of a run, leaves scan_en, scan_clk_en, vec_ready, resp_valid and done all at 0 in the cycle after the reset edge.
- R2: Each test's load step issues CHAIN_LEN shift pulses with scan_en=1 and vec_ready=1. The bit accepted first ends up in stage CHAIN_LEN-1, which is the scan-out end; each chain pulse with scan_en=1 moves stage k into stage k+1 and scan_in into stage 0.
- R3: When mode_los=1, each test accepts one extra bit as a launch shift with scan_en=1, making CHAIN_LEN+1 bits per test. Exactly one pulse with scan_en=0 (the capture) follows.
- R4: When mode_los=0, each test accepts CHAIN_LEN bits, then issues exactly two consecutive pulses with scan_en=0: launch, then capture.
- R5: While vec_ready=1 and vec_valid=0, no chain pulse is issued and no bit is consumed.
- R6: From the second test on, the load shifts out the previous response. The first bit out is stage CHAIN_LEN-1 and the last is stage 0, with resp_bit equal to scan_out on the same shift.
- R7: resp_valid is high only on shift pulses that carry captured data. It is never high before the first capture, and never on the extra launch shift.
- R8: After the last capture, exactly CHAIN_LEN flush shifts follow, with scan_in=0 and resp_valid=1.
- R9: done is high for exactly one cycle, after the flush. Then the block goes idle and issues no further pulses. A start with num_tests=0 gives the done pulse with no chain pulses at all.
- R10: mode_los and num_tests are sampled on start. Changes to either input, and extra start pulses, have no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle |
| mode_los | input | 1 | 1 = shift launch, 0 = capture launch |
| num_tests | input | PAT_W | Number of two-pattern tests in the run |
| vec_bit | input | 1 | Incoming test bit |
| vec_valid | input | 1 | vec_bit is valid |
| vec_ready | output | 1 | Block accepts a bit this cycle |
| scan_en | output | 1 | Scan enable of the chain |
| scan_clk_en | output | 1 | Chain clock-enable pulse |
| scan_in | output | 1 | Serial data into stage 0 |
| scan_out | input | 1 | Serial data from stage CHAIN_LEN-1 |
| resp_bit | output | 1 | Response bit |
| resp_valid | output | 1 | resp_bit carries captured data |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong step state or bit count shows up at the ports right away. The number of scan_en=0 pulses per test changes, or the number of bits consumed drifts from CHAIN_LEN or CHAIN_LEN+1. The response stream then stops matching the arithmetic model from the next unload on. A wrong first-test flag or launch-shift qualifier makes resp_valid rise before the first capture or on the launch shift, and the output bit count is off by the end of the run. A wrong flush length or test counter moves done, or repeats it, within one test's time.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LAUNCH,
    ST_CAPT,
    ST_FLUSH,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/scan_seq_bitcnt.sv
module scan_seq_bitcnt #(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             at_lim
);
  assign at_lim = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CHAIN_LEN));
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PAT_W     = 8,
  parameter int CNT_W     = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_los,
  input  logic [PAT_W-1:0] num_tests,
  input  logic             vec_valid,
  input  logic             at_lim,
  output seq_state_e       state,
  output logic             mode_q,
  output logic             first,
  output logic [CNT_W-1:0] limit
);
  logic [PAT_W-1:0] ntests_q;
  logic [PAT_W-1:0] tcnt;

  assign limit = (state == ST_LOAD && mode_q) ? CNT_W'(CHAIN_LEN) : CNT_W'(CHAIN_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= 1'b0;
      ntests_q <= '0;
      tcnt     <= '0;
      first    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mode_q   <= mode_los;
          ntests_q <= num_tests;
          tcnt     <= '0;
          first    <= 1'b1;
          state    <= (num_tests == '0) ? ST_DONE : ST_LOAD;
        end
        ST_LOAD: if (vec_valid && at_lim) state <= mode_q ? ST_CAPT : ST_LAUNCH;
        ST_LAUNCH: state <= ST_CAPT;
        ST_CAPT: begin
          first <= 1'b0;
          tcnt  <= tcnt + 1'b1;
          state <= (tcnt == ntests_q - 1'b1) ? ST_FLUSH : ST_LOAD;
        end
        ST_FLUSH: if (at_lim) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(mode_q) && $stable(ntests_q)));
endmodule

// File: rtl/scan_seq_decode.sv
module scan_seq_decode
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_state_e       state,
  input  logic             mode_q,
  input  logic             first,
  input  logic [CNT_W-1:0] cnt,
  input  logic             vec_valid,
  input  logic             vec_bit,
  output logic             scan_en,
  output logic             scan_clk_en,
  output logic             scan_in,
  output logic             vec_ready,
  output logic             resp_valid,
  output logic             done
);
  always_comb begin
    scan_en     = 1'b0;
    scan_clk_en = 1'b0;
    scan_in     = 1'b0;
    vec_ready   = 1'b0;
    resp_valid  = 1'b0;
    done        = 1'b0;
    case (state)
      ST_LOAD: begin
        scan_en     = 1'b1;
        vec_ready   = 1'b1;
        scan_clk_en = vec_valid;
        scan_in     = vec_bit;
        resp_valid  = vec_valid && !first && (cnt < CNT_W'(CHAIN_LEN));
      end
      ST_LAUNCH: scan_clk_en = 1'b1;
      ST_CAPT:   scan_clk_en = 1'b1;
      ST_FLUSH: begin
        scan_en     = 1'b1;
        scan_clk_en = 1'b1;
        resp_valid  = 1'b1;
      end
      ST_DONE: done = 1'b1;
      default: ;
    endcase
  end

  // R3
  los_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && mode_q) |-> $past(scan_clk_en && scan_en));
  // R4
  loc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && !mode_q) |-> $past(scan_clk_en && !scan_en));
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ready && !vec_valid) |-> !scan_clk_en);
  // R7
  resp_on_shift_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (scan_clk_en && scan_en));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PAT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_los,
  input  logic [PAT_W-1:0] num_tests,
  input  logic             vec_bit,
  input  logic             vec_valid,
  output logic             vec_ready,
  output logic             scan_en,
  output logic             scan_clk_en,
  output logic             scan_in,
  input  logic             scan_out,
  output logic             resp_bit,
  output logic             resp_valid,
  output logic             done
);
  localparam int CNT_W = $clog2(CHAIN_LEN + 1);

  seq_state_e       state;
  logic             mode_q;
  logic             first;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             at_lim;
  logic             shift_fire;
  logic             cnt_clr;

  assign shift_fire = scan_clk_en && scan_en;
  assign cnt_clr    = (shift_fire && at_lim) || (state == ST_IDLE);
  assign resp_bit   = scan_out;

  scan_seq_fsm #(.CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .mode_los(mode_los), .num_tests(num_tests),
    .vec_valid(vec_valid), .at_lim(at_lim), .state(state), .mode_q(mode_q),
    .first(first), .limit(limit)
  );

  scan_seq_bitcnt #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(shift_fire), .limit(limit),
    .cnt(cnt), .at_lim(at_lim)
  );

  scan_seq_decode #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .state(state), .mode_q(mode_q), .first(first), .cnt(cnt),
    .vec_valid(vec_valid), .vec_bit(vec_bit), .scan_en(scan_en),
    .scan_clk_en(scan_clk_en), .scan_in(scan_in), .vec_ready(vec_ready),
    .resp_valid(resp_valid), .done(done)
  );
endmodule

// File: tb/scan_seq_top_test.sv
module scan_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_los = 1'b0;
  logic [PW-1:0] num_tests = '0;
  logic vec_bit = 1'b0;
  logic vec_valid = 1'b0;
  logic vec_ready, scan_en, scan_clk_en, scan_in, resp_bit, resp_valid, done;
  logic [N-1:0] chain;
  logic scan_out;

  int checks = 0;
  int errors = 0;
  int gcyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_seq_top #(.CHAIN_LEN(N), .PAT_W(PW)) uut (
    .clk(clk), .rst(rst), .start(start), .mode_los(mode_los), .num_tests(num_tests),
    .vec_bit(vec_bit), .vec_valid(vec_valid), .vec_ready(vec_ready), .scan_en(scan_en),
    .scan_clk_en(scan_clk_en), .scan_in(scan_in), .scan_out(scan_out),
    .resp_bit(resp_bit), .resp_valid(resp_valid), .done(done)
  );

  function automatic logic [N-1:0] cut_f(input logic [N-1:0] q);
    return {q[2] ^ q[0], q[3] & q[1], ~q[0], q[1] | q[2]};
  endfunction

  // scan chain and circuit under test
  assign scan_out = chain[N-1];
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else if (scan_clk_en) chain <= scan_en ? {chain[N-2:0], scan_in} : cut_f(chain);
  end

  always @(posedge clk) begin
    gcyc <= gcyc + 1;
    if (gcyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected %0d", gcyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [N-1:0] v1_of(input int t, input int seed);
    return N'((t * 7 + seed * 3 + 5) % 16);
  endfunction
  function automatic logic launch_of(input int t);
    return logic'(t % 2);
  endfunction
  function automatic logic [N-1:0] resp_of(input int t, input int seed, input logic m);
    logic [N-1:0] v1, v2;
    v1 = v1_of(t, seed);
    v2 = m ? {v1[N-2:0], launch_of(t)} : cut_f(v1);
    return cut_f(v2);
  endfunction
  function automatic logic stream_bit(input int idx, input int b, input int nt, input int seed);
    int t, j;
    logic [N-1:0] v;
    t = idx / b;
    j = idx % b;
    if (t >= nt) return 1'b1;
    v = v1_of(t, seed);
    if (j < N) return v[N-1-j];
    return launch_of(t);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(!scan_en && !scan_clk_en && !vec_ready && !resp_valid && !done, req,
        {scan_en, scan_clk_en, vec_ready, resp_valid, done}, 0);
  endtask

  task automatic run_cfg(input logic m, input int nt, input int stall, input bit poke);
    int b, idx, rn, fpulse, spulse, dn, stall_bad, early, flush_bad, cyc, post;
    int seed;
    bit seen_done;
    logic [N-1:0] r;
    b = N + (m ? 1 : 0);
    seed = nt + stall * 4;
    idx = 0; rn = 0; fpulse = 0; spulse = 0; dn = 0;
    stall_bad = 0; early = 0; flush_bad = 0; cyc = 0; post = 0;
    seen_done = 0;
    @(posedge clk); #1;
    start = 1'b1; mode_los = m; num_tests = PW'(nt);
    while (post < 4 && cyc < 3000) begin
      @(negedge clk);
      if (done) dn++;
      if (seen_done && scan_clk_en) spulse += 1000;
      if (vec_ready && !vec_valid && scan_clk_en) stall_bad++;
      if (scan_clk_en && scan_en && !vec_ready && scan_in) flush_bad++;
      if (scan_clk_en && !scan_en) fpulse++;
      if (scan_clk_en && scan_en) spulse++;
      if (resp_valid) begin
        if (fpulse == 0) early++;
        r = resp_of(rn / N, seed, m);
        // R6 response order and value
        chk(resp_bit == r[N-1-(rn % N)], "R6", resp_bit, r[N-1-(rn % N)]);
        rn++;
      end
      if (vec_valid && vec_ready) idx++;
      if (seen_done) post++;
      if (done) seen_done = 1;
      @(posedge clk); #1;
      cyc++;
      start = poke && (cyc == 5 || cyc == 9);
      if (cyc > 0 && !poke) start = 1'b0;
      mode_los = poke ? ~m : m;
      num_tests = poke ? PW'(nt + 2) : PW'(nt);
      case (stall)
        0: vec_valid = 1'b1;
        1: vec_valid = (cyc % 3) != 1;
        default: vec_valid = (cyc % 5) < 2;
      endcase
      vec_bit = stream_bit(idx, b, nt, seed);
    end
    start = 1'b0;
    chk(cyc < 3000, "R9 run finishes", cyc, 0);
    chk(dn == 1, "R9 single done", dn, 1);
    chk(idx == nt * b, m ? "R3 bits consumed" : "R2 bits consumed", idx, nt * b);
    chk(fpulse == nt * (m ? 1 : 2), m ? "R3 capture pulses" : "R4 launch+capture pulses",
        fpulse, nt * (m ? 1 : 2));
    chk(spulse == (nt == 0 ? 0 : nt * b + N), "R8 shift pulses", spulse,
        nt == 0 ? 0 : nt * b + N);
    chk(rn == nt * N, "R7 response count", rn, nt * N);
    chk(early == 0, "R7 no data before capture", early, 0);
    chk(stall_bad == 0, "R5 stall holds", stall_bad, 0);
    chk(flush_bad == 0, "R8 flush scan_in zero", flush_bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1 reset state");
    @(posedge clk); #1;
    rst = 1'b0;
    for (int m = 0; m < 2; m++)
      for (int nt = 0; nt < 4; nt++)
        for (int s = 0; s < 3; s++)
          run_cfg(logic'(m), nt, s, 1'b0);
    // R10 mode, count and start ignored while busy
    run_cfg(1'b1, 2, 1, 1'b1);
    run_cfg(1'b0, 3, 0, 1'b1);
    // R1 mid-run reset
    @(posedge clk); #1;
    start = 1'b1; mode_los = 1'b0; num_tests = PW'(3); vec_valid = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 mid-run reset");
    repeat (3) @(negedge clk);
    check_idle("R1 stays idle");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule